// File: doc/BRIEF.md
# Multi-RAM Address Counter Self-Test Engine

This block is a self-test engine for a board memory made of six RAM slices that share one address. Slices 0 to 4 hold data pods and slice 5 holds instructions. Each slice is DW bits wide. All six slices see the same address, write strobe, write word and read strobe. Each slice returns its own read word one cycle after a read strobe.

A run starts with a one-cycle `start`. A 2-bit `subtest_sel` picks one of four loop values packed on `loop_cfg`. In the fill pass the engine writes every address in ascending order. Most addresses get the all-zeros background word. The addresses the selected loop value picks get the all-ones marker word. The same loop value is then reloaded and the address counters are cleared, so the verify pass starts again from address zero. The verify pass reads every address in ascending order and compares every slice with the expected word.

The outcome is a single word made of three fields. The low bits are a per-slice failure map. The middle field holds the row of the first failing address. The top bit is a range flag. `done` pulses once when the last comparison has been made. The result word then holds its value until the next accepted start.

Top module: `mram_addr_bist`

## Requirements
- R1: While `rst` is high and after it is released, the outputs are as follows: `busy`, `done`, `mem_we` and `mem_re` are 0, and `result` is 0.
- R2: The fill pass makes exactly one write per address, in ascending order. Each address is `{row, col}`, with the COL_W-bit column in the low bits. The column carries into the ROW_W-bit row when it wraps. Each written word is either 0x0000 or 0xFFFF.
- R3: Let L be the loop value `loop_cfg[subtest_sel*ADDR_W +: ADDR_W]`, sampled when the start is accepted. Address a receives 0xFFFF exactly when a mod (L+1) equals L. Every other address receives 0x0000.
- R4: After the fill, the counters restart at address 0. The verify pass then makes one read per address in ascending order. When all slices return the data written by the fill, `result` ends at 0.
- R5: Bit i of `result` (0 to 5) is set when slice i, taken from `mem_rdata[16i+15:16i]`, returned a wrong word at any point in the pass. Bits 0 to 4 are the pod slices and bit 5 is the instruction slice. The bits accumulate as an OR over the pass.
- R6: Bits 14:6 of `result` hold the row of the first failing address in read order. Later failures do not change this field.
- R7: Bit 15 of `result` is 1 when the latched failing row is 511 or more. Otherwise it is 0.
- R8: `done` is high for exactly one cycle, 2*A+2 cycles after the start is sampled, where A is the number of addresses. `busy` is high from the cycle after the accepted start until `done` rises.
- R9: After `done`, `result` holds its value until the next accepted start. The accepted start clears `result` to 0 one cycle later.
- R10: A `start` or a `subtest_sel` change while `busy` is high has no effect. The run keeps its timing, its write count and its original loop value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the engine is idle |
| subtest_sel | input | 2 | Chooses one of the four loop values |
| loop_cfg | input | 4*ADDR_W | Four packed loop values, entry k at bits k*ADDR_W |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 1+ROW_W+N_SLICE | Range flag, first failing row, per-slice failure map |
| mem_addr | output | ROW_W+COL_W | Shared RAM address, {row, col} |
| mem_we | output | 1 | Write strobe to all slices |
| mem_wdata | output | DW | Word written to all slices |
| mem_re | output | 1 | Read strobe to all slices |
| mem_rdata | input | N_SLICE*DW | Read words from the slices, one cycle after `mem_re` |

## Verification
The first write strobe appears on the edge after the start is accepted. The first read strobe appears A cycles later. `result` is cleared one cycle after the start, and `done` together with the final `result` arrives 2*A+2 cycles after the start edge. The bench drives inputs on falling edges and counts falling edges from the start. It checks the cleared result at count one and the end of the run at exactly count 2*A+2. A monitor tallies every write and read strobe against the ascending address order and the modulo marker rule. The tallies are checked once each run ends.

// File: rtl/mram_bist_pkg.sv
package mram_bist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_VERIFY,
    ST_DRAIN
  } bist_state_e;
endpackage

// File: rtl/mram_addr_gen.sv
module mram_addr_gen #(
  parameter int ROW_W = 9,
  parameter int COL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      col <= col + 1'b1;
      if (&col) row <= row + 1'b1;
    end
  end

  assign last = (&row) && (&col);

  // column wrap must advance the row by one
  p_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && (&col)) |=> (row == ROW_W'($past(row) + 1'b1)));

  // restart of the counters before the verify pass
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (row == '0 && col == '0));
endmodule

// File: rtl/mram_loop_ctr.sv
module mram_loop_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic         marker
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= period;
    else if (step) cnt <= marker ? period : cnt - 1'b1;
  end

  assign marker = (cnt == '0);

  // after a marker the countdown restarts from the loop value
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && marker) |=> (cnt == $past(period)));
endmodule

// File: rtl/mram_result_acc.sv
module mram_result_acc #(
  parameter int N_SLICE  = 6,
  parameter int DW       = 16,
  parameter int ROW_W    = 9,
  parameter int FLAG_ROW = 511,
  localparam int RES_W   = 1 + ROW_W + N_SLICE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  chk_v,
  input  logic                  chk_exp,
  input  logic [ROW_W-1:0]      chk_row,
  input  logic [N_SLICE*DW-1:0] rdata,
  output logic [RES_W-1:0]      result
);
  logic [N_SLICE-1:0] mis;
  logic [N_SLICE-1:0] fail_map;
  logic [ROW_W-1:0]   fail_row;
  logic               seen;
  logic               flag_q;

  for (genvar i = 0; i < N_SLICE; i++) begin : g_cmp
    assign mis[i] = chk_v && (rdata[i*DW +: DW] != {DW{chk_exp}});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail_map <= '0;
      fail_row <= '0;
      seen     <= 1'b0;
      flag_q   <= 1'b0;
    end else if (|mis) begin
      fail_map <= fail_map | mis;
      if (!seen) begin
        fail_row <= chk_row;
        flag_q   <= (chk_row >= ROW_W'(FLAG_ROW));
        seen     <= 1'b1;
      end
    end
  end

  assign result = {flag_q, fail_row, fail_map};

  // failure bits never drop within a pass
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((fail_map & $past(fail_map)) == $past(fail_map)));

  // the first failing row is kept
  p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && !clr) |=> $stable(fail_row));

  // range flag consistent with the latched row
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> (fail_row >= ROW_W'(FLAG_ROW)));
endmodule

// File: rtl/mram_addr_bist.sv
module mram_addr_bist
  import mram_bist_pkg::*;
#(
  parameter int N_SLICE  = 6,
  parameter int DW       = 16,
  parameter int ROW_W    = 9,
  parameter int COL_W    = 2,
  parameter int FLAG_ROW = 511,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int RES_W   = 1 + ROW_W + N_SLICE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            subtest_sel,
  input  logic [4*ADDR_W-1:0]   loop_cfg,
  output logic                  busy,
  output logic                  done,
  output logic [RES_W-1:0]      result,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [DW-1:0]         mem_wdata,
  output logic                  mem_re,
  input  logic [N_SLICE*DW-1:0] mem_rdata
);
  bist_state_e       state;
  logic [ADDR_W-1:0] per_q, sel_period, lc_period;
  logic [ROW_W-1:0]  row, e1_row, s2_row;
  logic [COL_W-1:0]  col;
  logic              last, marker, accept, step, ag_clr, fin;
  logic              e1_exp, e1_last, s2_v, s2_exp, s2_last;

  assign sel_period = loop_cfg[subtest_sel*ADDR_W +: ADDR_W];
  assign lc_period  = (state == ST_IDLE) ? sel_period : per_q;
  assign accept     = (state == ST_IDLE) && start;
  assign step       = (state == ST_FILL) || (state == ST_VERIFY);
  assign ag_clr     = accept || ((state == ST_FILL) && last);
  assign fin        = s2_v && s2_last;

  mram_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst(rst), .clr(ag_clr), .step(step),
    .row(row), .col(col), .last(last)
  );

  mram_loop_ctr #(.W(ADDR_W)) u_loop (
    .clk(clk), .rst(rst), .load(ag_clr), .step(step),
    .period(lc_period), .marker(marker)
  );

  mram_result_acc #(
    .N_SLICE(N_SLICE), .DW(DW), .ROW_W(ROW_W), .FLAG_ROW(FLAG_ROW)
  ) u_acc (
    .clk(clk), .rst(rst), .clr(accept), .chk_v(s2_v), .chk_exp(s2_exp),
    .chk_row(s2_row), .rdata(mem_rdata), .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      per_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      e1_exp    <= 1'b0;
      e1_row    <= '0;
      e1_last   <= 1'b0;
      s2_v      <= 1'b0;
      s2_exp    <= 1'b0;
      s2_row    <= '0;
      s2_last   <= 1'b0;
    end else begin
      mem_we    <= (state == ST_FILL);
      mem_re    <= (state == ST_VERIFY);
      mem_addr  <= {row, col};
      mem_wdata <= {DW{marker}};
      e1_exp    <= marker;
      e1_row    <= row;
      e1_last   <= (state == ST_VERIFY) && last;
      s2_v      <= mem_re;
      s2_exp    <= e1_exp;
      s2_row    <= e1_row;
      s2_last   <= mem_re && e1_last;
      done      <= fin;
      case (state)
        ST_IDLE: if (start) begin
          per_q <= sel_period;
          busy  <= 1'b1;
          state <= ST_FILL;
        end
        ST_FILL:   if (last) state <= ST_VERIFY;
        ST_VERIFY: if (last) state <= ST_DRAIN;
        ST_DRAIN: if (fin) begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // strobes never overlap
  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // done lasts one cycle and ends the busy window
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // result frozen while idle without a start
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  // a start during a run does not restart it
  p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

// File: tb/sim_mram_addr_bist.sv
`timescale 1ns/1ps
module sim_mram_addr_bist;
  localparam int NS = 6, DW = 16, ROW_W = 9, COL_W = 1;
  localparam int AW = ROW_W + COL_W, A = 1 << AW, RW = 1 + ROW_W + NS;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] sel = '0;
  logic [4*AW-1:0] loop_cfg = '0;
  logic busy, done, mem_we, mem_re;
  logic [RW-1:0] result;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NS*DW-1:0] mem_rdata;

  int vectors = 0, miscmp = 0;
  logic fen0 = 1'b0, fen1 = 1'b0;
  int fa0 = 0, fa1 = 0;
  logic [NS*DW-1:0] fm0 = '0, fm1 = '0;
  int cur_L = 0;
  logic mon_clr = 1'b0;
  int wr_n, rd_n, seq_err, pat_err;

  always #5 clk = ~clk;

  mram_addr_bist #(.N_SLICE(NS), .DW(DW), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .subtest_sel(sel), .loop_cfg(loop_cfg),
    .busy(busy), .done(done), .result(result), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic is_mark(int a, int l);
    return (a % (l + 1)) == l;
  endfunction

  logic [NS*DW-1:0] ram [A];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= {NS{mem_wdata}};
    if (mem_re)
      mem_rdata <= ram[mem_addr]
                 ^ ((fen0 && int'(mem_addr) == fa0) ? fm0 : '0)
                 ^ ((fen1 && int'(mem_addr) == fa1) ? fm1 : '0);
  end

  always @(posedge clk) begin
    if (mon_clr) begin
      wr_n <= 0; rd_n <= 0; seq_err <= 0; pat_err <= 0;
    end else begin
      if (mem_we) begin
        if (int'(mem_addr) != wr_n) seq_err <= seq_err + 1;
        if (mem_wdata != (is_mark(wr_n, cur_L) ? 16'hFFFF : 16'h0000)) pat_err <= pat_err + 1;
        wr_n <= wr_n + 1;
      end
      if (mem_re) begin
        if (int'(mem_addr) != rd_n) seq_err <= seq_err + 1;
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one full run; cyc = falling edges from start edge to done
  task automatic run_bist(input logic [1:0] s, input bit restart,
                          output int cyc, output logic [RW-1:0] res_early);
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    sel = s; cur_L = int'(loop_cfg[s*AW +: AW]); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0; res_early = '0;
    forever begin
      @(negedge clk); cyc++;
      if (cyc == 1) res_early = result;
      if (restart && cyc == 100) begin start = 1'b1; sel = s + 2'd1; end
      if (restart && cyc == 101) start = 1'b0;
      if (done) break;
      if (cyc > 4 * A + 100) begin
        miscmp++; $display("FAIL R8: run timeout actual %0d expected %0d", cyc, 2 * A + 2);
        break;
      end
    end
    sel = s;
  endtask

  task automatic common_checks(input string tag, input int cyc);
    chk({tag, " R8 done latency"}, cyc, 2 * A + 2);
    chk({tag, " R8 busy at done"}, busy, 0);
    chk({tag, " R2 write count"}, wr_n, A);
    chk({tag, " R4 read count"}, rd_n, A);
    chk({tag, " R2/R4 address order"}, seq_err, 0);
    chk({tag, " R3 marker pattern"}, pat_err, 0);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
  endtask

  task automatic t_subtests();
    int cyc; logic [RW-1:0] re;
    loop_cfg = {10'd37, 10'd1023, 10'd6, 10'd0};
    for (int s = 0; s < 4; s++) begin
      run_bist(2'(s), 1'b0, cyc, re);
      chk($sformatf("sub%0d R4 clean result", s), result, 0);
      common_checks($sformatf("sub%0d", s), cyc);
    end
  endtask

  task automatic t_single();
    int cyc; logic [RW-1:0] re;
    fen0 = 1'b1; fa0 = 7; fm0 = '0; fm0[2*DW +: DW] = 16'h0100;
    run_bist(2'd1, 1'b0, cyc, re);
    chk("R5 R6 slice2 row3", result, 16'h00C4);
    common_checks("single", cyc);
    fen0 = 1'b0;
  endtask

  task automatic t_multi();
    int cyc; logic [RW-1:0] re;
    fen0 = 1'b1; fa0 = 400; fm0 = '0; fm0[0 +: DW] = 16'h8000;
    fen1 = 1'b1; fa1 = 11;  fm1 = '0; fm1[5*DW +: DW] = 16'h0001;
    run_bist(2'd3, 1'b0, cyc, re);
    chk("R5 R6 slices0,5 first row5", result, 16'h0161);
    common_checks("multi", cyc);
    fen0 = 1'b0; fen1 = 1'b0;
  endtask

  task automatic t_range();
    int cyc; logic [RW-1:0] re;
    fen0 = 1'b1; fa0 = 1023; fm0 = '0; fm0[4*DW +: DW] = 16'hFFFF;
    run_bist(2'd2, 1'b0, cyc, re);
    chk("R7 row511 flag set", result, 16'hFFD0);
    common_checks("row511", cyc);
    fa0 = 1021; fm0 = '0; fm0[3*DW +: DW] = 16'h0010;
    run_bist(2'd0, 1'b0, cyc, re);
    chk("R7 row510 flag clear", result, 16'h7F88);
    common_checks("row510", cyc);
    fen0 = 1'b0;
  endtask

  task automatic t_hold_ignore();
    int cyc; logic [RW-1:0] re;
    fen0 = 1'b1; fa0 = 50; fm0 = '0; fm0[1*DW +: DW] = 16'h0040;
    run_bist(2'd1, 1'b1, cyc, re);
    chk("R10 restart ignored result", result, 16'h0642);
    common_checks("R10 restart", cyc);
    repeat (30) @(negedge clk);
    chk("R9 result held", result, 16'h0642);
    fen0 = 1'b0;
    run_bist(2'd0, 1'b0, cyc, re);
    chk("R9 cleared after start", re, 0);
    chk("R9 clean after clear", result, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_subtests();
    t_single();
    t_multi();
    t_range();
    t_hold_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule